// File: doc/BRIEF.md
# Patching Instruction Fetch Controller

This block sits between a 256-word instruction memory and a small processor core. It fetches words one after another. It rewrites selected words before the core sees them, so that the core receives a live external measurement as immediate data and never needs a dedicated input port.

Two reserved marker words are recognised as they come back from memory. In each marker, the low half is replaced by one half of a 32-bit measurement input. A third word form is a block jump. It names two of the sixteen 16-word memory blocks. The fetch address moves to the first word of one of them, chosen by a live phase flag that says whether the reference clock leads. The jump word itself reaches the core as a harmless no-operation.

While the core's fetch enable is low, fetching pauses and the address is held.

Top module: `fetch_patch_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `instr_valid` is 0 and `mem_addr` is 0.
- R2: A word requested in one cycle (`fetch_en` high) is delivered in the next cycle with `instr_valid` high and `instr_addr` equal to the requested address. A cycle without a request yields `instr_valid` low in the following cycle. `mem_rd_en` equals `fetch_en`.
- R3: A returned word equal to 0x198004D2 is delivered with bits [31:16] unchanged (0x1980) and bits [15:0] equal to `meas_value[31:16]`, sampled in the delivery cycle.
- R4: A returned word equal to 0xA98C162F is delivered with bits [31:16] unchanged (0xA98C) and bits [15:0] equal to `meas_value[15:0]`, sampled in the delivery cycle.
- R5: A block-jump word has bits [31:26] = 0x1C, bits [25:8] = 0, the lag block in bits [7:4] and the lead block in bits [3:0]. When it is delivered with `ref_leads` high, `mem_addr` in that same cycle is the lead block number times 16.
- R6: When a block-jump word is delivered with `ref_leads` low, `mem_addr` in that same cycle is the lag block number times 16.
- R7: A block-jump word is delivered as the no-operation word 0x15000000. A word with opcode 0x1C and any nonzero bit in [25:8] is not a jump: it passes through unchanged and does not redirect.
- R8: With no jump delivered, each request is for the address after the previous one, wrapping from 255 to 0.
- R9: While `fetch_en` is low, the address is held. A jump delivered in such a cycle still sets the address that the next request will use.
- R10: Any word other than the three forms above is delivered unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Core asks for the next instruction this cycle |
| ref_leads | input | 1 | High when the reference clock leads the divided clock |
| meas_value | input | 32 | Measurement value to be injected into marker words |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 32 | Memory read data, one cycle after the strobe |
| instr_valid | output | 1 | Delivered instruction is valid |
| instr_addr | output | 8 | Memory address of the delivered instruction |
| instr_data | output | 32 | Delivered, possibly rewritten, instruction |

## Verification
Two things can fall in the same cycle: the return of a jump word, and the issue of the next request, which must already use the jump target. A jump can also land on another jump, or land while the fetch enable is low. The bench provokes these cases with back-to-back jump words, a jump that leads into a marker, and random fetch-enable and phase-flag patterns. It compares every cycle's address, valid flag and delivered word against a behavioural model that tracks the outstanding request. A word with the jump opcode and a nonzero middle field is placed on the path to confirm that it neither redirects nor is replaced.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int          WORD_W   = 32;
    localparam int          BLK_W    = 4;
    localparam logic [31:0] MARK_HI  = 32'h1980_04D2;
    localparam logic [31:0] MARK_LO  = 32'hA98C_162F;
    localparam logic [31:0] NOP_WORD = 32'h1500_0000;
    localparam logic [5:0]  JUMP_OPC = 6'h1C;

    typedef enum logic [1:0] {
        WK_PLAIN,
        WK_INJ_HI,
        WK_INJ_LO,
        WK_JUMP
    } word_kind_e;

    typedef struct packed {
        word_kind_e       kind;
        logic [BLK_W-1:0] lag_blk;
        logic [BLK_W-1:0] lead_blk;
    } word_info_t;

    function automatic word_info_t classify(input logic [WORD_W-1:0] w);
        word_info_t info;
        info.lead_blk = w[BLK_W-1:0];
        info.lag_blk  = w[2*BLK_W-1:BLK_W];
        if (w == MARK_HI)
            info.kind = WK_INJ_HI;
        else if (w == MARK_LO)
            info.kind = WK_INJ_LO;
        else if (w[31:26] == JUMP_OPC && w[25:2*BLK_W] == '0)
            info.kind = WK_JUMP;
        else
            info.kind = WK_PLAIN;
        return info;
    endfunction

endpackage

// File: rtl/fpc_word_decode.sv
module fpc_word_decode
    import fpc_pkg::*;
(
    input  logic                 word_valid,
    input  logic [WORD_W-1:0]    word_in,
    input  logic [WORD_W-1:0]    meas_value,
    input  logic                 ref_leads,
    output logic [WORD_W-1:0]    word_out,
    output logic                 redirect,
    output logic [BLK_W-1:0]     tgt_blk
);

    word_info_t info;

    always_comb begin
        info     = classify(word_in);
        word_out = word_in;
        redirect = 1'b0;
        tgt_blk  = ref_leads ? info.lead_blk : info.lag_blk;
        if (word_valid) begin
            unique case (info.kind)
                WK_INJ_HI: word_out = {word_in[31:16], meas_value[31:16]};
                WK_INJ_LO: word_out = {word_in[31:16], meas_value[15:0]};
                WK_JUMP: begin
                    word_out = NOP_WORD;
                    redirect = 1'b1;
                end
                default:   word_out = word_in;
            endcase
        end
    end

endmodule

// File: rtl/fpc_addr_gen.sv
module fpc_addr_gen
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic              redirect,
    input  logic [BLK_W-1:0]  tgt_blk,
    output logic [ADDR_W-1:0] next_addr
);

    localparam int              OFF_W = ADDR_W - BLK_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    always_comb begin
        next_addr = redirect ? {tgt_blk, {OFF_W{1'b0}}} : pc_q;
        pc_d      = fetch_en ? next_addr + STEP : next_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

endmodule

// File: rtl/fpc_resp_stage.sv
module fpc_resp_stage #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
        end else begin
            pend_valid <= fetch_en;
            if (fetch_en) pend_addr <= req_addr;
        end
    end

endmodule

// File: rtl/fetch_patch_ctrl.sv
module fetch_patch_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic              ref_leads,
    input  logic [31:0]       meas_value,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              instr_valid,
    output logic [ADDR_W-1:0] instr_addr,
    output logic [31:0]       instr_data
);

    logic              redirect;
    logic [BLK_W-1:0]  tgt_blk;
    logic [ADDR_W-1:0] next_addr;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;

    fpc_word_decode u_dec (
        .word_valid (pend_valid),
        .word_in    (mem_rdata),
        .meas_value (meas_value),
        .ref_leads  (ref_leads),
        .word_out   (instr_data),
        .redirect   (redirect),
        .tgt_blk    (tgt_blk)
    );

    fpc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .fetch_en  (fetch_en),
        .redirect  (redirect),
        .tgt_blk   (tgt_blk),
        .next_addr (next_addr)
    );

    fpc_resp_stage #(.ADDR_W(ADDR_W)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .fetch_en   (fetch_en),
        .req_addr   (next_addr),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr)
    );

    assign mem_rd_en   = fetch_en;
    assign mem_addr    = next_addr;
    assign instr_valid = pend_valid;
    assign instr_addr  = pend_addr;

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_en,
    input logic              ref_leads,
    input logic [31:0]       meas_value,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_rdata,
    input logic              instr_valid,
    input logic [ADDR_W-1:0] instr_addr,
    input logic [31:0]       instr_data
);

    logic jmp_now;
    assign jmp_now = instr_valid && mem_rdata[31:26] == 6'h1C && mem_rdata[25:8] == 18'd0;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!instr_valid && mem_addr == '0));

    a_r2_deliver: assert property (@(posedge clk) disable iff (rst)
        fetch_en |=> (instr_valid && instr_addr == $past(mem_addr)));

    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        !fetch_en |=> !instr_valid);

    a_r3_inject_hi: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && mem_rdata == 32'h1980_04D2) |-> instr_data == {16'h1980, meas_value[31:16]});

    a_r4_inject_lo: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && mem_rdata == 32'hA98C_162F) |-> instr_data == {16'hA98C, meas_value[15:0]});

    a_r5_lead_target: assert property (@(posedge clk) disable iff (rst)
        (jmp_now && ref_leads) |-> mem_addr == ADDR_W'({mem_rdata[3:0], 4'h0}));

    a_r6_lag_target: assert property (@(posedge clk) disable iff (rst)
        (jmp_now && !ref_leads) |-> mem_addr == ADDR_W'({mem_rdata[7:4], 4'h0}));

    a_r7_jump_nop: assert property (@(posedge clk) disable iff (rst)
        jmp_now |-> instr_data == 32'h1500_0000);

    a_r8_sequential: assert property (@(posedge clk) disable iff (rst)
        (fetch_en && !jmp_now) ##1 !jmp_now |-> mem_addr == ADDR_W'($past(mem_addr) + 1));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!fetch_en && !jmp_now) ##1 !jmp_now |-> mem_addr == $past(mem_addr));

    a_r2_rd_strobe: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en == fetch_en);

endmodule

bind fetch_patch_ctrl fpc_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .fetch_en    (fetch_en),
    .ref_leads   (ref_leads),
    .meas_value  (meas_value),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rdata   (mem_rdata),
    .instr_valid (instr_valid),
    .instr_addr  (instr_addr),
    .instr_data  (instr_data)
);

// File: tb/fetch_patch_ctrl_tb_top.sv
`timescale 1ns/1ps
module fetch_patch_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_en = 1'b0;
    logic        ref_leads = 1'b0;
    logic [31:0] meas_value = '0;
    logic        mem_rd_en;
    logic [7:0]  mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        instr_valid;
    logic [7:0]  instr_addr;
    logic [31:0] instr_data;

    logic [31:0] mem [256];

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    fetch_patch_ctrl dut_i (
        .clk(clk), .rst(rst), .fetch_en(fetch_en), .ref_leads(ref_leads),
        .meas_value(meas_value), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .instr_valid(instr_valid), .instr_addr(instr_addr),
        .instr_data(instr_data)
    );

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int m_pc = 0;
        bit m_pv = 0;
        int m_pa = 0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h8C00_0000 | (i * 32'h0001_0301);
        mem[0]   = 32'h1980_04D2;
        mem[1]   = 32'hA98C_162F;
        mem[2]   = 32'h7000_0053;
        mem[48]  = 32'hA98C_162F;
        mem[49]  = 32'h7000_0053;
        mem[80]  = 32'h7000_00EF;
        mem[81]  = 32'h1980_04D2;
        mem[230] = 32'h1980_04D2;
        mem[245] = 32'h7000_0153;
        mem[251] = 32'h7000_8001;

        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'd0, instr_valid}, 32'd0);
        check("R1 reset addr", {24'd0, mem_addr}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 first addr", {24'd0, mem_addr}, 32'd0);
        check("R1 first valid", {31'd0, instr_valid}, 32'd0);

        for (int cyc = 0; cyc < 4000; cyc++) begin
            logic [31:0] w;
            logic [31:0] exp_data;
            bit          jmp;
            int          nxt;
            string       tag;
            if (cyc > 0) @(negedge clk);
            fetch_en   = (cyc < 40) ? 1'b1 : (($urandom % 5) != 0);
            ref_leads  = (cyc < 20) ? 1'b0 : $urandom % 2;
            meas_value = $urandom;
            #1;
            w   = mem[m_pa];
            jmp = m_pv && w[31:26] == 6'h1C && w[25:8] == 18'd0;
            nxt = jmp ? (ref_leads ? w[3:0] * 16 : w[7:4] * 16) : m_pc;

            if (jmp)           tag = ref_leads ? "R5 lead target" : "R6 lag target";
            else if (fetch_en) tag = "R8 next addr";
            else               tag = "R9 held addr";
            check(tag, {24'd0, mem_addr}, nxt);
            check("R2 rd strobe", {31'd0, mem_rd_en}, {31'd0, fetch_en});
            check("R2 valid", {31'd0, instr_valid}, {31'd0, m_pv});
            if (m_pv) begin
                check("R2 instr addr", {24'd0, instr_addr}, m_pa);
                if (w == 32'h1980_04D2) begin
                    exp_data = {w[31:16], meas_value[31:16]}; tag = "R3 hi inject";
                end else if (w == 32'hA98C_162F) begin
                    exp_data = {w[31:16], meas_value[15:0]};  tag = "R4 lo inject";
                end else if (jmp) begin
                    exp_data = 32'h1500_0000;                 tag = "R7 jump nop";
                end else if (w[31:26] == 6'h1C) begin
                    exp_data = w;                             tag = "R7 non-jump form";
                end else begin
                    exp_data = w;                             tag = "R10 passthrough";
                end
                check(tag, instr_data, exp_data);
            end

            m_pv = fetch_en;
            if (fetch_en) begin
                m_pa = nxt;
                m_pc = (nxt + 1) % 256;
            end else begin
                m_pc = nxt;
            end
        end
        finish_run();
    end

endmodule